// File: doc/BRIEF.md
# Inter-processor doorbell and MSI unit

This block holds a per-CPU doorbell cause register and a per-CPU enable mask, and raises doorbell bits in them from a single shared trigger register. One write to the trigger register carries both a doorbell number and a bitmap of target CPUs. Every selected CPU gets that doorbell bit set in its cause register. Software uses it to send inter-processor interrupts. A bus master raises a message-signalled interrupt by writing the value `0xF00 | (16 + n)` to the same trigger address, which rings doorbell 16+n on all four CPUs.

Each CPU has two summary outputs for its interrupt controller. The low summary covers doorbells 0 to 7 (inter-processor) and the high summary covers doorbells 16 to 31 (message-signalled). A handler reads its cause register and writes back the complement of what it saw, which clears only those bits. It then services them. A bit written as 1 in the cause register is left alone, so doorbells that arrive during servicing stay pending. The block has no state machine. All of its state is held in the cause and mask registers, which are reset to zero.

Top module: `db_unit`

## Requirements
- R1: After reset every cause and mask register reads 0 and both summary vectors are 0.
- R2: A global write to offset 0x04 sets cause bit `wdata[4:0]` in every CPU c for which `wdata[8+c]` is 1. The cause registers of all other CPUs are unchanged.
- R3: Global writes to any offset other than 0x04 change no cause register.
- R4: A private write to offset 0x08 of CPU c clears each cause bit written as 0 and keeps each bit written as 1.
- R5: A private write to offset 0x0C loads that CPU's mask register, and a read of offset 0x0C returns the value written.
- R6: `ipi_irq[c]` is 1 exactly when some bit in 7:0 is set in both the cause and the mask of CPU c.
- R7: `msi_irq[c]` is 1 exactly when some bit in 31:16 is set in both the cause and the mask of CPU c.
- R8: Cause bits 15:8 can be set and read back, but they never drive either summary output.
- R9: If a trigger and a cause clear-write hit the same bit in the same cycle, the bit ends up set.
- R10: A trigger value of `0xF00 | (16+n)`, for n from 0 to 15, sets bit 16+n in all four cause registers.
- R11: A private read of offset 0x08 returns the cause register and a read of 0x0C returns the mask. A read of any other offset returns 0.
- R12: Doorbells raised after a handler reads its cause register stay set when the handler writes back the complement of the bits it read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_wr | input | 1 | Write strobe for the shared global window |
| glb_addr | input | 8 | Global byte offset |
| glb_wdata | input | 32 | Global write data |
| prv_wr | input | 1 | Write strobe for a CPU's private window |
| prv_cpu | input | 2 | CPU whose private window is written |
| prv_addr | input | 8 | Private byte offset |
| prv_wdata | input | 32 | Private write data |
| rd_cpu | input | 2 | CPU whose private window is read |
| rd_addr | input | 8 | Private read offset |
| rd_data | output | 32 | Combinational read data |
| ipi_irq | output | 4 | Per-CPU summary for doorbells 7:0 |
| msi_irq | output | 4 | Per-CPU summary for doorbells 31:16 |

## Verification
The bench sweeps all 32 doorbell numbers against all 16 target bitmaps with every mask enabled. A decoder that shifted the bitmap field or took a wrong number width would set bits on the wrong CPU or at the wrong position. A walking single-bit mask over a fully set cause register finds summary ranges whose edges are off by one, and it finds the reserved middle byte leaking into a summary. The bench also drives a same-cycle trigger and clear: a design that lets the clear win would lose that doorbell. The handler sequence of read, new doorbell, then complement write catches a clear that wipes the whole register instead of only the bits that were read.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam int DB_W    = 32;
    localparam int NUM_W   = $clog2(DB_W);
    localparam int MAP_LSB = 8;

    localparam logic [7:0] OFF_TRIG  = 8'h04;
    localparam logic [7:0] OFF_CAUSE = 8'h08;
    localparam logic [7:0] OFF_MASK  = 8'h0C;

    localparam int IPI_LO = 0;
    localparam int IPI_HI = 7;
    localparam int MSI_LO = 16;
    localparam int MSI_HI = 31;
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
    import db_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8
) (
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DB_W-1:0]            wdata,
    output logic [NCPU-1:0][DB_W-1:0]  set_vec
);
    logic            hit;
    logic [DB_W-1:0] onehot;

    always_comb begin
        hit    = wr && (addr == ADDR_W'(OFF_TRIG));
        onehot = DB_W'(1) << wdata[NUM_W-1:0];
        for (int c = 0; c < NCPU; c++) begin
            set_vec[c] = (hit && wdata[MAP_LSB + c]) ? onehot : '0;
        end
    end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_bits,
    input  logic            clr_wr,
    input  logic            mask_wr,
    input  logic [DB_W-1:0] wdata,
    output logic [DB_W-1:0] cause,
    output logic [DB_W-1:0] mask
);
    logic [DB_W-1:0] cause_nxt;

    always_comb begin
        cause_nxt = (clr_wr ? (cause & wdata) : cause) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            cause <= cause_nxt;
            if (mask_wr) begin
                mask <= wdata;
            end
        end
    end

    a_r9_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((cause & $past(set_bits)) == $past(set_bits)));

    a_r4_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && set_bits == '0) |=> (cause == ($past(cause) & $past(wdata))));

    a_r12_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && set_bits == '0) |=> $stable(cause));

    a_r5_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wdata)));

    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask));
endmodule

// File: rtl/db_summary.sv
module db_summary
    import db_pkg::*;
(
    input  logic [DB_W-1:0] cause,
    input  logic [DB_W-1:0] mask,
    output logic            ipi,
    output logic            msi
);
    logic [DB_W-1:0] live;

    always_comb begin
        live = cause & mask;
        ipi  = |live[IPI_HI:IPI_LO];
        msi  = |live[MSI_HI:MSI_LO];
    end
endmodule

// File: rtl/db_unit.sv
module db_unit
    import db_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_wr,
    input  logic [ADDR_W-1:0] glb_addr,
    input  logic [DB_W-1:0]   glb_wdata,
    input  logic              prv_wr,
    input  logic [CPU_W-1:0]  prv_cpu,
    input  logic [ADDR_W-1:0] prv_addr,
    input  logic [DB_W-1:0]   prv_wdata,
    input  logic [CPU_W-1:0]  rd_cpu,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DB_W-1:0]   rd_data,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   msi_irq
);
    logic [NCPU-1:0][DB_W-1:0] set_vec;
    logic [NCPU-1:0][DB_W-1:0] cause_arr;
    logic [NCPU-1:0][DB_W-1:0] mask_arr;

    db_trig_decode #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_dec (
        .wr      (glb_wr),
        .addr    (glb_addr),
        .wdata   (glb_wdata),
        .set_vec (set_vec)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic sel;
        assign sel = prv_wr && (prv_cpu == CPU_W'(c));

        db_cpu_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_vec[c]),
            .clr_wr   (sel && (prv_addr == ADDR_W'(OFF_CAUSE))),
            .mask_wr  (sel && (prv_addr == ADDR_W'(OFF_MASK))),
            .wdata    (prv_wdata),
            .cause    (cause_arr[c]),
            .mask     (mask_arr[c])
        );

        db_summary u_sum (
            .cause (cause_arr[c]),
            .mask  (mask_arr[c]),
            .ipi   (ipi_irq[c]),
            .msi   (msi_irq[c])
        );
    end

    always_comb begin
        if (rd_addr == ADDR_W'(OFF_CAUSE)) begin
            rd_data = cause_arr[rd_cpu];
        end else if (rd_addr == ADDR_W'(OFF_MASK)) begin
            rd_data = mask_arr[rd_cpu];
        end else begin
            rd_data = '0;
        end
    end

    a_r3_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_wr && !prv_wr) |=> ($stable(ipi_irq) && $stable(msi_irq)));
endmodule

// File: tb/db_unit_test.sv
module db_unit_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_wr = 1'b0;
    logic [7:0]  glb_addr = '0;
    logic [31:0] glb_wdata = '0;
    logic        prv_wr = 1'b0;
    logic [1:0]  prv_cpu = '0;
    logic [7:0]  prv_addr = '0;
    logic [31:0] prv_wdata = '0;
    logic [1:0]  rd_cpu = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [3:0]  msi_irq;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    db_unit uut (
        .clk(clk), .rst_n(rst_n),
        .glb_wr(glb_wr), .glb_addr(glb_addr), .glb_wdata(glb_wdata),
        .prv_wr(prv_wr), .prv_cpu(prv_cpu), .prv_addr(prv_addr), .prv_wdata(prv_wdata),
        .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
        .ipi_irq(ipi_irq), .msi_irq(msi_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic gwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        glb_wr = 1'b1; glb_addr = a; glb_wdata = d;
        @(negedge clk);
        glb_wr = 1'b0;
    endtask

    task automatic pwrite(input int c, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        prv_wr = 1'b1; prv_cpu = 2'(c); prv_addr = a; prv_wdata = d;
        @(negedge clk);
        prv_wr = 1'b0;
    endtask

    task automatic both_write(input logic [31:0] gd, input int c, input logic [31:0] pd);
        @(negedge clk);
        glb_wr = 1'b1; glb_addr = 8'h04; glb_wdata = gd;
        prv_wr = 1'b1; prv_cpu = 2'(c); prv_addr = 8'h08; prv_wdata = pd;
        @(negedge clk);
        glb_wr = 1'b0; prv_wr = 1'b0;
    endtask

    task automatic rd(input int c, input logic [7:0] a, output logic [31:0] d);
        rd_cpu = 2'(c); rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clear_all();
        for (int c = 0; c < 4; c++) pwrite(c, 8'h08, 32'h0);
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  e_ipi, e_msi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 4; c++) begin
            rd(c, 8'h08, d); chk("R1 cause", d, 32'h0);
            rd(c, 8'h0C, d); chk("R1 mask", d, 32'h0);
        end
        chk("R1 ipi", 32'(ipi_irq), 32'h0);
        chk("R1 msi", 32'(msi_irq), 32'h0);

        // R5 mask load and readback
        for (int c = 0; c < 4; c++) begin
            pwrite(c, 8'h0C, 32'hFFFFFFFF);
            rd(c, 8'h0C, d); chk("R5 mask", d, 32'hFFFFFFFF);
        end

        // R2 R6 R7 R8 exhaustive number x bitmap sweep
        for (int n = 0; n < 32; n++) begin
            for (int m = 0; m < 16; m++) begin
                gwrite(8'h04, (32'(m) << 8) | 32'(n));
                e_ipi = '0; e_msi = '0;
                for (int c = 0; c < 4; c++) begin
                    rd(c, 8'h08, d);
                    chk("R2 cause", d, m[c] ? (32'h1 << n) : 32'h0);
                    e_ipi[c] = m[c] && (n < 8);
                    e_msi[c] = m[c] && (n >= 16);
                end
                chk("R6 ipi", 32'(ipi_irq), 32'(e_ipi));
                chk("R7 msi", 32'(msi_irq), 32'(e_msi));
                clear_all();
            end
        end

        // R8 walking mask over full cause of cpu0
        for (int n = 0; n < 32; n++) gwrite(8'h04, 32'h100 | 32'(n));
        rd(0, 8'h08, d); chk("R8 all bits set", d, 32'hFFFFFFFF);
        for (int k = 0; k < 32; k++) begin
            pwrite(0, 8'h0C, 32'h1 << k);
            #1;
            chk("R6 walk ipi", 32'(ipi_irq[0]), (k < 8) ? 32'h1 : 32'h0);
            chk("R7 walk msi", 32'(msi_irq[0]), (k >= 16) ? 32'h1 : 32'h0);
        end
        pwrite(0, 8'h0C, 32'h0000FF00);
        #1;
        chk("R8 mid byte silent", 32'({ipi_irq[0], msi_irq[0]}), 32'h0);
        pwrite(0, 8'h0C, 32'hFFFFFFFF);
        clear_all();

        // R3 other global offsets ignored
        gwrite(8'h00, 32'h00000F05);
        gwrite(8'h08, 32'h00000F05);
        gwrite(8'h0C, 32'h00000F15);
        for (int c = 0; c < 4; c++) begin
            rd(c, 8'h08, d); chk("R3 cause untouched", d, 32'h0);
        end
        chk("R3 ipi", 32'(ipi_irq), 32'h0);

        // R4 partial clear
        gwrite(8'h04, 32'h801); gwrite(8'h04, 32'h805); gwrite(8'h04, 32'h811);
        pwrite(3, 8'h08, 32'hFFFFFFDF);
        rd(3, 8'h08, d); chk("R4 partial clear", d, 32'h00020002);
        clear_all();

        // R9 trigger vs clear same cycle
        both_write(32'h203, 1, 32'h0);
        rd(1, 8'h08, d); chk("R9 trigger wins", d, 32'h8);
        clear_all();

        // R10 message-signalled values
        for (int n = 0; n < 16; n++) begin
            gwrite(8'h04, 32'hF00 | 32'(16 + n));
            for (int c = 0; c < 4; c++) begin
                rd(c, 8'h08, d); chk("R10 msi ring", d, 32'h1 << (16 + n));
            end
            chk("R10 msi irq", 32'(msi_irq), 32'hF);
            clear_all();
        end

        // R11 read decode
        gwrite(8'h04, 32'h406);
        rd(2, 8'h08, d); chk("R11 read cause", d, 32'h40);
        rd(2, 8'h00, d); chk("R11 read other", d, 32'h0);
        rd(2, 8'h04, d); chk("R11 read trig off", d, 32'h0);
        clear_all();

        // R12 handler sequence keeps late doorbells
        gwrite(8'h04, 32'h402);
        rd(2, 8'h08, d);
        gwrite(8'h04, 32'h414);
        pwrite(2, 8'h08, ~d);
        rd(2, 8'h08, d); chk("R12 late doorbell kept", d, 32'h00100000);
        chk("R12 msi still up", 32'(msi_irq[2]), 32'h1);
        chk("R12 ipi dropped", 32'(ipi_irq[2]), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule